// File: doc/BRIEF.md
# Line Signal Detect Qualifier

This block decides whether a real signal is present on a twisted-pair receive line. An external comparator produces a one-cycle strobe for every pulse that crosses its current threshold. The block counts these strobes and raises `signal_detect` once enough pulses have arrived close together. When detect is high, the block tells the comparator to use its lower threshold and tells the clock recovery loop to follow the received data instead of the local transmit serial clock.

The way detect drops depends on the line rate. At 100 Mb/s an idle timer runs from the most recent valid pulse, and detect clears when no pulse has arrived for a fixed number of reference-clock cycles. At 10 Mb/s the timer has no effect, and detect follows a Manchester-activity indication from the 10 Mb/s decoder. Whenever detect drops, the threshold returns to the squelch level and the clock reference returns to the transmit clock.

Top module: `sigdet_qual`

## Requirements
- R1: `signal_detect` rises on the clock edge that samples the QUAL_PULSES-th (default 2) valid pulse. A single isolated pulse leaves it low.
- R2: `thr_low_sel` is 1 (reduced, unsquelch level) exactly when `signal_detect` is 1. It is 0 (squelch level) otherwise.
- R3: With `speed_100`=1, detect stays high through IDLE_CYCLES-1 (default 149) edges after the edge of the last valid pulse. It falls on edge IDLE_CYCLES (150).
- R4: With `speed_100`=0, the idle timer is ignored and detect stays high for any idle length while `manch_act`=1. Detect falls on the first edge that samples `manch_act`=0.
- R5: `cdr_ref_rx` is 1 (recovery loop follows the received signal) exactly when `signal_detect` is 1. It is 0 (local transmit serial clock) otherwise.
- R6: A pending partial pulse count is discarded when no further pulse arrives within IDLE_CYCLES edges. A second pulse 150 edges after the first still qualifies, but one 151 edges after does not.
- R7: Reset forces all three outputs to 0 and clears the pulse count, so a single pulse after reset does not assert detect.
- R8: With `speed_100`=0, qualification also requires `manch_act`=1 when the final pulse is sampled.
- R9: In 100 Mb/s mode, every valid pulse while detect is high restarts the idle timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (125 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pulse_ok | input | 1 | One-cycle strobe per valid line pulse from the comparator |
| manch_act | input | 1 | Manchester data currently being received (10 Mb/s) |
| speed_100 | input | 1 | 1 = 100 Mb/s rules, 0 = 10 Mb/s rules |
| signal_detect | output | 1 | Qualified signal present |
| thr_low_sel | output | 1 | 1 = unsquelch (lower) threshold, 0 = squelch threshold |
| cdr_ref_rx | output | 1 | 1 = recovery loop tracks received signal, 0 = transmit clock |

## Verification
The bench builds the block with its defaults: IDLE_CYCLES = 150 and QUAL_PULSES = 2. This lets it place pulses exactly at the 149/150/151-cycle boundaries of the idle window, both for the fall of detect and for the loss of a half-built count. It also holds 10 Mb/s activity well past the 150-cycle window to show the timer has no effect there. The two-pulse threshold makes the one-pulse-not-enough case a direct single-strobe test.

// File: rtl/sigdet_pkg.sv
package sigdet_pkg;
  typedef enum logic {
    ST_SQUELCH = 1'b0,
    ST_DETECT  = 1'b1
  } sd_state_e;
endpackage

// File: rtl/sd_reset_sync.sv
module sd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sd_idle_timer.sv
module sd_idle_timer #(
  parameter int LIMIT = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic expire_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_V  = W'(LIMIT);
  localparam logic [W-1:0] LAST_V = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  // Restart on a pulse, otherwise count up and saturate at the limit.
  always_comb begin
    cnt_en = pulse_i || (cnt_q != LIM_V);
    cnt_d  = pulse_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = !pulse_i && (cnt_q == LAST_V);

  p_timer_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_V);
  p_timer_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |=> (cnt_q == '0));
endmodule

// File: rtl/sd_pulse_counter.sv
module sd_pulse_counter #(
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  input  logic clear_i,
  output logic last_o
);
  localparam int W = $clog2(QUAL + 1);
  localparam logic [W-1:0] QUAL_V = W'(QUAL);
  localparam logic [W-1:0] PRE_V  = W'(QUAL - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clear_i || (pulse_i && (cnt_q != QUAL_V));
    cnt_d  = clear_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Next valid pulse completes qualification.
  assign last_o = (cnt_q == PRE_V);

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= QUAL_V);
  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/sd_state_ctl.sv
module sd_state_ctl
  import sigdet_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  input  logic last_i,
  input  logic expire_i,
  input  logic manch_i,
  input  logic speed_100_i,
  output logic det_o,
  output logic thr_low_o,
  output logic cdr_rx_o
);
  sd_state_e state_q, state_d;
  logic      qualify, drop;

  always_comb begin
    qualify = pulse_i && last_i && (speed_100_i || manch_i);
    drop    = speed_100_i ? expire_i : !manch_i;
    state_d = state_q;
    unique case (state_q)
      ST_SQUELCH: if (qualify) state_d = ST_DETECT;
      ST_DETECT:  if (drop)    state_d = ST_SQUELCH;
      default:                 state_d = ST_SQUELCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_SQUELCH;
      det_o     <= 1'b0;
      thr_low_o <= 1'b0;
      cdr_rx_o  <= 1'b0;
    end else begin
      state_q   <= state_d;
      det_o     <= (state_d == ST_DETECT);
      thr_low_o <= (state_d == ST_DETECT);
      cdr_rx_o  <= (state_d == ST_DETECT);
    end
  end

  p_rise_needs_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_o) |-> $past(pulse_i));
  p_fast_fall_timer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(det_o) && $past(speed_100_i)) |-> $past(expire_i));
  p_slow_fall_manch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(det_o) && !$past(speed_100_i)) |-> !$past(manch_i));
  p_slow_rise_manch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(det_o) && !$past(speed_100_i)) |-> $past(manch_i));
endmodule

// File: rtl/sigdet_qual.sv
module sigdet_qual #(
  parameter int IDLE_CYCLES = 150,
  parameter int QUAL_PULSES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_ok,
  input  logic manch_act,
  input  logic speed_100,
  output logic signal_detect,
  output logic thr_low_sel,
  output logic cdr_ref_rx
);
  logic rst_n_i;
  logic expire;
  logic last_pulse;

  sd_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  sd_idle_timer #(.LIMIT(IDLE_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .pulse_i  (pulse_ok),
    .expire_o (expire)
  );

  sd_pulse_counter #(.QUAL(QUAL_PULSES)) u_count (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .pulse_i (pulse_ok),
    .clear_i (expire || signal_detect),
    .last_o  (last_pulse)
  );

  sd_state_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .pulse_i     (pulse_ok),
    .last_i      (last_pulse),
    .expire_i    (expire),
    .manch_i     (manch_act),
    .speed_100_i (speed_100),
    .det_o       (signal_detect),
    .thr_low_o   (thr_low_sel),
    .cdr_rx_o    (cdr_ref_rx)
  );

  p_reset_quiet_r7: assert property (@(posedge clk)
    !rst_n_i |-> (!signal_detect && !thr_low_sel && !cdr_ref_rx));
endmodule

// File: tb/tb_sigdet_qual.sv
module tb_sigdet_qual;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_ok = 1'b0;
  logic manch_act = 1'b0;
  logic speed_100 = 1'b1;
  logic signal_detect, thr_low_sel, cdr_ref_rx;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  sigdet_qual dut (
    .clk(clk), .rst_n(rst_n), .pulse_ok(pulse_ok), .manch_act(manch_act),
    .speed_100(speed_100), .signal_detect(signal_detect),
    .thr_low_sel(thr_low_sel), .cdr_ref_rx(cdr_ref_rx)
  );

  task automatic check(input bit act, input bit exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // All three outputs must agree with the expected detect value.
  task automatic check_all(input bit exp, input string req);
    check(signal_detect, exp, req);
    check(thr_low_sel, exp, {req, " R2 threshold"});
    check(cdr_ref_rx, exp, {req, " R5 clock ref"});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pulse();
    pulse_ok = 1'b1;
    @(negedge clk);
    pulse_ok = 1'b0;
  endtask

  task automatic do_reset(input bit spd, input bit man);
    @(negedge clk);
    rst_n = 1'b0; pulse_ok = 1'b0; speed_100 = spd; manch_act = man;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_reset_state();
    do_reset(1'b1, 1'b0);
    check_all(1'b0, "R7 reset state");
  endtask

  task automatic t_single_pulse();
    do_reset(1'b1, 1'b0);
    send_pulse();
    idle(5);
    check_all(1'b0, "R1 single pulse");
  endtask

  task automatic t_qualify_and_timeout();
    do_reset(1'b1, 1'b0);
    send_pulse();
    idle(3);
    send_pulse();
    check_all(1'b1, "R1 two pulses");
    idle(149);
    check(signal_detect, 1'b1, "R3 high at 149 idle");
    idle(1);
    check_all(1'b0, "R3 low at 150 idle");
  endtask

  task automatic t_restart();
    do_reset(1'b1, 1'b0);
    send_pulse(); send_pulse();
    idle(100);
    send_pulse();
    idle(120);
    check(signal_detect, 1'b1, "R9 restart keeps detect");
    idle(29);
    check(signal_detect, 1'b1, "R9 high at 149 after restart");
    idle(1);
    check(signal_detect, 1'b0, "R9 low at 150 after restart");
  endtask

  task automatic t_gap_edges();
    do_reset(1'b1, 1'b0);
    send_pulse();
    idle(149);
    send_pulse();
    check(signal_detect, 1'b1, "R6 gap 150 qualifies");
    do_reset(1'b1, 1'b0);
    send_pulse();
    idle(150);
    send_pulse();
    check(signal_detect, 1'b0, "R6 gap 151 discarded");
    idle(2);
    send_pulse();
    check(signal_detect, 1'b1, "R6 fresh pair after discard");
  endtask

  task automatic t_slow_mode();
    do_reset(1'b0, 1'b1);
    send_pulse(); send_pulse();
    check_all(1'b1, "R1 10M two pulses");
    idle(300);
    check(signal_detect, 1'b1, "R4 timer ignored at 10M");
    manch_act = 1'b0;
    @(negedge clk);
    check_all(1'b0, "R4 drop on manchester loss");
  endtask

  task automatic t_slow_needs_manch();
    do_reset(1'b0, 1'b0);
    send_pulse(); send_pulse(); send_pulse();
    check(signal_detect, 1'b0, "R8 no manchester no detect");
  endtask

  task automatic t_reset_clears();
    do_reset(1'b1, 1'b0);
    send_pulse();
    do_reset(1'b1, 1'b0);
    send_pulse();
    idle(2);
    check(signal_detect, 1'b0, "R7 count cleared by reset");
  endtask

  initial begin
    t_reset_state();
    t_single_pulse();
    t_qualify_and_timeout();
    t_restart();
    t_gap_edges();
    t_slow_mode();
    t_slow_needs_manch();
    t_reset_clears();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule